// File: doc/BRIEF.md
# Register File with Mirrored Output Taps

This block is the architectural register store of a small RISC core. It holds sixteen general-purpose registers. Two read ports are combinational and one write-back port is clocked. The two read buses and the write-back result bus are visible at the block boundary. Because of this, a function unit placed next to the core can take its operands from the same reads the core performs and return its result through the ordinary write-back path.

The block also has a set of mirror taps. Each tap pairs a 4-bit watch selector with an output register. When the register a tap watches is written, the tap's output register takes the same value on the same clock edge. It makes no difference which instruction produced the value: a move, a logic operation or an add all behave the same way.

As a result, a peripheral sees a control word that any write-back instruction can update, at one new word per cycle when writes follow each other. Each tap also raises a one-cycle strobe whenever its output is reloaded. Every tap watches its register independently of the others. A tap's selector is written through its own enable and applies to writes from the following clock onward.

Top module: `regfile_mirror`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all sixteen registers, every tap output and every strobe to zero, and sets every selector to zero (register 0 watched).
- R2: A write with `wbEn` high stores `wbData` into register `wbAddr` at the clock edge. Both read ports return the contents of the addressed register combinationally.
- R3: When a read port addresses the register being written in the same cycle, it returns the old contents until the edge. No bypass is provided.
- R4: When a write targets the register named by a tap's selector, that tap's output takes the written value at the same edge. The tap's strobe is high during the following cycle.
- R5: A write to any register other than the one a tap watches leaves that tap's output unchanged, and its strobe stays low.
- R6: Writes to a watched register on consecutive cycles reload the tap every cycle, and its strobe stays high for each of those cycles.
- R7: A selector write (`selWrEn[i]` high, new index in bits `[4*i+3:4*i]` of `selWrData`) takes effect at the edge. A register write in that same cycle is still matched against the previous selector.
- R8: Taps work independently. Two taps with equal selectors both load from one write, and taps with different selectors load only on their own register.
- R9: A cycle with `wbEn` low changes no register and no tap output, and all strobes are low in the next cycle.
- R10: The result bus outputs (`resultEn`, `resultAddr`, `resultData`) carry the write-back inputs unchanged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 4 | Read port A register index |
| rdAddrB | input | 4 | Read port B register index |
| rdDataA | output | DATA_W | Read port A data (combinational) |
| rdDataB | output | DATA_W | Read port B data (combinational) |
| wbEn | input | 1 | Write-back enable |
| wbAddr | input | 4 | Write-back register index |
| wbData | input | DATA_W | Write-back value |
| resultEn | output | 1 | Exported result bus enable |
| resultAddr | output | 4 | Exported result bus index |
| resultData | output | DATA_W | Exported result bus value |
| selWrEn | input | NUM_VIEWS | Per-tap selector write enable |
| selWrData | input | 4*NUM_VIEWS | Per-tap new selector, 4 bits per tap |
| viewData | output | DATA_W*NUM_VIEWS | Tap outputs, tap i in bits [DATA_W*i +: DATA_W] |
| viewStrobe | output | NUM_VIEWS | One-cycle pulse per tap reload |

## Verification
Two functions can fall in the same cycle. The first is a selector change together with a register write: the bench writes register 0 in the very cycle it moves both selectors away from 0, and expects both taps to load under the old selectors. The second is a read and a write to the same index: the bench points a read port at the register being written and expects the old value before the edge and the new one after it. The scoreboard predicts every tap output and strobe from the selector and register model it keeps for each cycle.

// File: rtl/regfile_mirror_pkg.sv
`timescale 1ns/1ps
package regfile_mirror_pkg;
  localparam int REG_COUNT = 16;
  localparam int IDX_W = $clog2(REG_COUNT);
  typedef logic [IDX_W-1:0] regIdx_t;
  // strobe bundle from control to datapath
  typedef struct packed {
    logic    commit;
    regIdx_t idx;
  } wbCmd_t;
endpackage

// File: rtl/regfile_mirror_ctrl.sv
`timescale 1ns/1ps
module regfile_mirror_ctrl
  import regfile_mirror_pkg::*;
#(
  parameter int NUM_VIEWS = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wbEn,
  input  regIdx_t                    wbAddr,
  input  logic [NUM_VIEWS-1:0]       selWrEn,
  input  logic [IDX_W*NUM_VIEWS-1:0] selWrData,
  output wbCmd_t                     cmd,
  output logic [NUM_VIEWS-1:0]       viewLoad
);
  always_comb begin
    cmd.commit = wbEn && !rst;
    cmd.idx    = wbAddr;
  end

  for (genvar i = 0; i < NUM_VIEWS; i++) begin : gSel
    regIdx_t selQ;
    always_ff @(posedge clk) begin
      if (rst) selQ <= '0;
      else if (selWrEn[i]) selQ <= selWrData[IDX_W*i +: IDX_W];
    end
    // compare against the selector held before this edge
    assign viewLoad[i] = cmd.commit && (cmd.idx == selQ);
  end
endmodule

// File: rtl/regfile_mirror_dp.sv
`timescale 1ns/1ps
module regfile_mirror_dp
  import regfile_mirror_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_VIEWS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  wbCmd_t                        cmd,
  input  logic [DATA_W-1:0]             wbData,
  input  logic [NUM_VIEWS-1:0]          viewLoad,
  input  regIdx_t                       rdAddrA,
  input  regIdx_t                       rdAddrB,
  output logic [DATA_W-1:0]             rdDataA,
  output logic [DATA_W-1:0]             rdDataB,
  output logic [DATA_W*NUM_VIEWS-1:0]   viewData,
  output logic [NUM_VIEWS-1:0]          viewStrobe
);
  logic [DATA_W-1:0] regs [REG_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < REG_COUNT; k++) regs[k] <= '0;
    end else if (cmd.commit) begin
      regs[cmd.idx] <= wbData;
    end
  end

  // asynchronous reads, no write bypass
  assign rdDataA = regs[rdAddrA];
  assign rdDataB = regs[rdAddrB];

  for (genvar i = 0; i < NUM_VIEWS; i++) begin : gView
    logic [DATA_W-1:0] viewQ;
    logic              strobeQ;
    always_ff @(posedge clk) begin
      if (rst) begin
        viewQ   <= '0;
        strobeQ <= 1'b0;
      end else begin
        strobeQ <= viewLoad[i];
        if (viewLoad[i]) viewQ <= wbData;
      end
    end
    assign viewData[DATA_W*i +: DATA_W] = viewQ;
    assign viewStrobe[i] = strobeQ;
  end
endmodule

// File: rtl/regfile_mirror.sv
`timescale 1ns/1ps
module regfile_mirror
  import regfile_mirror_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int NUM_VIEWS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [3:0]                    rdAddrA,
  input  logic [3:0]                    rdAddrB,
  output logic [DATA_W-1:0]             rdDataA,
  output logic [DATA_W-1:0]             rdDataB,
  input  logic                          wbEn,
  input  logic [3:0]                    wbAddr,
  input  logic [DATA_W-1:0]             wbData,
  output logic                          resultEn,
  output logic [3:0]                    resultAddr,
  output logic [DATA_W-1:0]             resultData,
  input  logic [NUM_VIEWS-1:0]          selWrEn,
  input  logic [4*NUM_VIEWS-1:0]        selWrData,
  output logic [DATA_W*NUM_VIEWS-1:0]   viewData,
  output logic [NUM_VIEWS-1:0]          viewStrobe
);
  wbCmd_t               cmd;
  logic [NUM_VIEWS-1:0] viewLoad;

  // exported result bus for neighbouring function units
  assign resultEn   = wbEn;
  assign resultAddr = wbAddr;
  assign resultData = wbData;

  regfile_mirror_ctrl #(.NUM_VIEWS(NUM_VIEWS)) uCtrl (
    .clk(clk), .rst(rst), .wbEn(wbEn), .wbAddr(wbAddr),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .cmd(cmd), .viewLoad(viewLoad)
  );

  regfile_mirror_dp #(.DATA_W(DATA_W), .NUM_VIEWS(NUM_VIEWS)) uDp (
    .clk(clk), .rst(rst), .cmd(cmd), .wbData(wbData), .viewLoad(viewLoad),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB),
    .viewData(viewData), .viewStrobe(viewStrobe)
  );
endmodule

// File: rtl/regfile_mirror_chk.sv
`timescale 1ns/1ps
module regfile_mirror_chk #(
  parameter int DATA_W    = 16,
  parameter int NUM_VIEWS = 2
) (
  input logic                        clk,
  input logic                        rst,
  input logic [3:0]                  rdAddrA,
  input logic [DATA_W-1:0]           rdDataA,
  input logic                        wbEn,
  input logic [3:0]                  wbAddr,
  input logic [DATA_W-1:0]           wbData,
  input logic [DATA_W*NUM_VIEWS-1:0] viewData,
  input logic [NUM_VIEWS-1:0]        viewStrobe
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= !rst;

  AST_READ_SEES_WRITE: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(wbEn) && rdAddrA == $past(wbAddr)) |-> rdDataA == $past(wbData)); // R2

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(wbEn) |-> viewStrobe == '0); // R9

  for (genvar i = 0; i < NUM_VIEWS; i++) begin : gTap
    AST_STROBE_CARRIES_DATA: assert property (@(posedge clk) disable iff (rst || !armed)
      viewStrobe[i] |-> (viewData[DATA_W*i +: DATA_W] == $past(wbData))); // R4
    AST_VIEW_HOLDS: assert property (@(posedge clk) disable iff (rst || !armed)
      !viewStrobe[i] |-> $stable(viewData[DATA_W*i +: DATA_W])); // R5
  end
endmodule

bind regfile_mirror regfile_mirror_chk #(.DATA_W(DATA_W), .NUM_VIEWS(NUM_VIEWS)) uChk (
  .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
  .wbEn(wbEn), .wbAddr(wbAddr), .wbData(wbData),
  .viewData(viewData), .viewStrobe(viewStrobe)
);

// File: tb/regfile_mirror_test.sv
`timescale 1ns/1ps
module regfile_mirror_test;
  localparam int W  = 16;
  localparam int NV = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  logic rst = 1'b1;
  logic [3:0] rdAddrA = '0, rdAddrB = '0;
  logic [W-1:0] rdDataA, rdDataB;
  logic wbEn = 1'b0;
  logic [3:0] wbAddr = '0;
  logic [W-1:0] wbData = '0;
  logic resultEn;
  logic [3:0] resultAddr;
  logic [W-1:0] resultData;
  logic [NV-1:0] selWrEn = '0;
  logic [4*NV-1:0] selWrData = '0;
  logic [W*NV-1:0] viewData;
  logic [NV-1:0] viewStrobe;

  regfile_mirror uut (
    .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdAddrB(rdAddrB),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .wbEn(wbEn), .wbAddr(wbAddr),
    .wbData(wbData), .resultEn(resultEn), .resultAddr(resultAddr),
    .resultData(resultData), .selWrEn(selWrEn), .selWrData(selWrData),
    .viewData(viewData), .viewStrobe(viewStrobe)
  );

  int checks = 0;
  int fails  = 0;

  // reference model
  logic [W-1:0] mReg [16];
  logic [3:0]   mSel [NV];
  logic [W-1:0] mView [NV];

  logic [W*NV+NV-1:0] expQ [$];
  string              tagQ [$];

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one cycle, check reads/result bus before the edge, queue tap expectation
  task automatic step(input bit r, input bit en, input logic [3:0] a, input logic [W-1:0] d,
                      input logic [NV-1:0] se, input logic [4*NV-1:0] sd,
                      input logic [3:0] ra, input logic [3:0] rb, input bit chk, input string tag);
    logic [W*NV-1:0] ev;
    logic [NV-1:0]   es;
    @(negedge clk);
    rst = r; wbEn = en; wbAddr = a; wbData = d; selWrEn = se; selWrData = sd;
    rdAddrA = ra; rdAddrB = rb;
    #1;
    if (chk && !r) begin
      check(rdDataA == mReg[ra], {tag, " portA"}, rdDataA, mReg[ra]);
      check(rdDataB == mReg[rb], {tag, " portB"}, rdDataB, mReg[rb]);
      check(resultEn == en && resultAddr == a && resultData == d, "R10 result bus echo", resultData, d);
    end
    if (r) begin
      for (int k = 0; k < 16; k++) mReg[k] = '0;
      for (int i = 0; i < NV; i++) begin mSel[i] = '0; mView[i] = '0; es[i] = 1'b0; end
    end else begin
      for (int i = 0; i < NV; i++) begin
        es[i] = en && (a == mSel[i]);
        if (es[i]) mView[i] = d;
      end
      for (int i = 0; i < NV; i++) if (se[i]) mSel[i] = sd[4*i +: 4];
      if (en) mReg[a] = d;
    end
    for (int i = 0; i < NV; i++) ev[W*i +: W] = mView[i];
    expQ.push_back({ev, es});
    tagQ.push_back(tag);
  endtask

  // monitor: compares tap outputs after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        logic [W*NV+NV-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        for (int i = 0; i < NV; i++) begin
          check(viewData[W*i +: W] == e[NV + W*i +: W], {t, " tap data"}, viewData[W*i +: W], e[NV + W*i +: W]);
          check(viewStrobe[i] == e[i], {t, " tap strobe"}, {15'd0, viewStrobe[i]}, {15'd0, e[i]});
        end
      end
    end
  end

  initial begin
    #(8 * 50000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 reset");
    // R1: registers read zero, selectors at 0 so a write to register 0 hits both taps
    step(0, 0, 0, 0, 0, 0, 4'd7, 4'd15, 1, "R1 cleared regs");
    step(0, 1, 0, 16'hA5A5, 0, 0, 4'd0, 4'd3, 1, "R1 R4 default selector");
    // R7: move selectors to 5 and 9 while writing register 0 -> old selectors apply
    step(0, 1, 0, 16'h1111, 2'b11, {4'd9, 4'd5}, 4'd0, 4'd0, 1, "R7 same-cycle selector");
    step(0, 0, 0, 0, 0, 0, 4'd0, 4'd1, 1, "R9 idle");
    // R5 R8: only tap 0 watches register 5
    step(0, 1, 5, 16'h0505, 0, 0, 4'd5, 4'd5, 1, "R8 tap0 only");
    step(0, 1, 2, 16'h2222, 0, 0, 4'd5, 4'd0, 1, "R5 unwatched");
    // R6: burst into register 9
    step(0, 1, 9, 16'h9001, 0, 0, 4'd9, 4'd9, 1, "R6 burst");
    step(0, 1, 9, 16'h9002, 0, 0, 4'd9, 4'd2, 1, "R3 R6 burst");
    step(0, 1, 9, 16'h9003, 0, 0, 4'd9, 4'd9, 1, "R3 R6 burst");
    // R9: disabled write to watched register
    step(0, 0, 5, 16'hDEAD, 0, 0, 4'd5, 4'd9, 1, "R9 no enable");
    step(0, 0, 9, 16'hBEEF, 0, 0, 4'd5, 4'd9, 1, "R9 no enable");
    // R8: both taps on register 3
    step(0, 0, 0, 0, 2'b11, {4'd3, 4'd3}, 4'd3, 4'd3, 1, "R8 retarget");
    step(0, 1, 3, 16'h3C3C, 0, 0, 4'd3, 4'd3, 1, "R8 shared");
    step(0, 1, 3, 16'h4D4D, 2'b01, {4'd0, 4'd15}, 4'd3, 4'd3, 1, "R7 R8 shared");
    step(0, 1, 15, 16'hF0F0, 0, 0, 4'd3, 4'd15, 1, "R8 tap0 on 15");
    // R2: fill every register, reading back the previous one
    for (int k = 0; k < 16; k++)
      step(0, 1, 4'(k), 16'(k * 16'h0101 + 16'h0033), 0, 0, 4'(k - 1), 4'(15 - k), 1, "R2 fill");
    for (int k = 0; k < 16; k++)
      step(0, 0, 0, 0, 0, 0, 4'(k), 4'(15 - k), 1, "R2 readback");
    // R3: read follows write to the same register
    step(0, 1, 6, 16'h6666, 0, 0, 4'd6, 4'd6, 1, "R3 old value");
    step(0, 0, 0, 0, 0, 0, 4'd6, 4'd6, 1, "R3 new value");
    // R1: reset in the middle clears everything
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 mid reset");
    step(0, 0, 0, 0, 0, 0, 4'd6, 4'd15, 1, "R1 after reset");
    step(0, 1, 0, 16'h7777, 0, 0, 4'd0, 4'd0, 1, "R1 selectors zero");
    step(0, 0, 0, 0, 0, 0, 4'd0, 4'd0, 1, "R9 tail");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule